// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block is the bus master that sits between a processor core and external memory on a narrow multiplexed bus. The core raises a request for one of three operations: a code fetch from program space, a data read or a data write. Each request carries a 16-bit byte address, and a write also carries one byte. The controller runs one fixed-length bus cycle for the request. The low address byte and the data share one 8-bit port, one after the other. The high address byte has a port of its own.

An external transparent latch captures the low address byte on the falling edge of the address strobe. After that edge the shared port carries data. Program-space reads are marked by their own active-low strobe. Data-space reads and writes each have a separate active-low strobe. At most one of these three strobes is low at any time. When the cycle completes, the core gets a one-clock done pulse and, for reads, the byte sampled from the bus.

A cycle lasts five clocks. In the address clock the address strobe is high and the address is driven. In the hold clock the strobe has fallen and the low address is still driven. Two data clocks follow with the selected strobe low. In the release clock the strobe is high and done is raised.

Top module: `mux_bus_master`

## Requirements
- R1: After reset and whenever idle, `req_ready` is 1, `ale` is 0, `psen_n`, `rd_n` and `wr_n` are 1, and `rsp_done` is 0.
- R2: In the first clock of a cycle, `ale` is 1 and `ad_out` carries address bits 7..0 with `ad_oe` = 1. `ale` then falls while the same low byte is still driven for one more clock, so a latch closing on that falling edge holds the request's low address.
- R3: `addr_hi` carries address bits 15..8 of the request and stays unchanged while any strobe is low.
- R4: A fetch (`req_kind` = 2'b00) drives `psen_n` low for exactly two clocks, with `rd_n` and `wr_n` held high.
- R5: A data read (`req_kind` = 2'b01) drives `rd_n` low for exactly two clocks, with `psen_n` and `wr_n` high. For every read kind, `ad_oe` is 0 for as long as the read strobe is low. `rsp_data` is the value of `ad_in` at the last clock edge before the strobe rises.
- R6: A data write (`req_kind` = 2'b10) drives `wr_n` low for exactly two clocks, with `psen_n` and `rd_n` high. `ad_out` holds the write byte with `ad_oe` = 1 from the first data clock through the clock in which `wr_n` rises.
- R7: No two of `psen_n`, `rd_n` and `wr_n` are low at the same time.
- R8: `rsp_done` is high for exactly one clock, four clocks after the clock in which `ale` is high. A request is taken only when `req_ready` is 1, so a request raised during a busy cycle starts nothing.
- R9: `req_kind` = 2'b11 is reserved. Such a request is not accepted and no bus cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request present |
| req_kind | input | 2 | 00 fetch, 01 data read, 10 data write, 11 reserved |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Controller idle and able to take a request |
| rsp_data | output | 8 | Byte read by the last fetch or read |
| rsp_done | output | 1 | One-clock completion pulse |
| ale | output | 1 | Address latch strobe, low byte captured on its fall |
| psen_n | output | 1 | Active-low program-space read strobe |
| rd_n | output | 1 | Active-low data read strobe |
| wr_n | output | 1 | Active-low data write strobe |
| addr_hi | output | 8 | Address bits 15..8 |
| ad_out | output | 8 | Shared port, outbound value (low address, then write data) |
| ad_oe | output | 1 | Output enable for the shared port |
| ad_in | input | 8 | Shared port, inbound value from the external device |

## Verification
The bench models a falling-edge address latch, a program store computed from the address, and a data store that takes bytes when the write strobe rises. Every cycle is scored on three things: the address the latch actually captured, which strobe went low and for how long, and the data moved. Addresses 0x0000, 0xFFFF and alternating-bit patterns show whether the high and low bytes have been swapped or cut short. Writing a location and then reading it back, next to reads of locations that were never written, shows whether data goes into the device in the right direction at the right time. Back-to-back cycles, requests raised while busy, and the reserved kind show whether the controller starts cycles only when it should.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'b00,
        KIND_READ  = 2'b01,
        KIND_WRITE = 2'b10,
        KIND_RSVD  = 2'b11
    } bus_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ADDR = 3'd1,
        PH_HOLD = 3'd2,
        PH_DATA = 3'd3,
        PH_REL  = 3'd4
    } bus_phase_e;

endpackage

// File: rtl/mbus_seq.sv
module mbus_seq
    import mbus_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int DATA_CLKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] ad_in,
    output bus_phase_e        phase,
    output bus_kind_e         kind,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int CNT_W = (DATA_CLKS > 1) ? $clog2(DATA_CLKS) : 1;
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_CLKS - 1);

    typedef struct packed {
        bus_phase_e        phase;
        logic [CNT_W-1:0]  cnt;
        bus_kind_e         kind;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (st_q.phase)
            PH_IDLE: begin
                if (req_valid && (bus_kind_e'(req_kind) != KIND_RSVD)) begin
                    st_d.phase = PH_ADDR;
                    st_d.kind  = bus_kind_e'(req_kind);
                    st_d.addr  = req_addr;
                    st_d.wdata = req_wdata;
                    st_d.cnt   = '0;
                end
            end
            PH_ADDR: st_d.phase = PH_HOLD;
            PH_HOLD: begin
                st_d.phase = PH_DATA;
                st_d.cnt   = '0;
            end
            PH_DATA: begin
                if (st_q.cnt == LAST_DATA) begin
                    st_d.phase = PH_REL;
                    if (st_q.kind != KIND_WRITE) begin
                        st_d.rdata = ad_in;
                    end
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_REL:  st_d.phase = PH_IDLE;
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, cnt: '0, kind: KIND_FETCH,
                      addr: '0, wdata: '0, rdata: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.phase;
    assign kind  = st_q.kind;
    assign addr  = st_q.addr;
    assign wdata = st_q.wdata;
    assign rdata = st_q.rdata;

endmodule

// File: rtl/mbus_strobe.sv
module mbus_strobe
    import mbus_pkg::*;
(
    input  bus_phase_e phase,
    input  bus_kind_e  kind,
    output logic       ale,
    output logic       psen_n,
    output logic       rd_n,
    output logic       wr_n,
    output logic       done,
    output logic       ready
);
    logic in_data;

    always_comb begin
        in_data = (phase == PH_DATA);
        ale     = (phase == PH_ADDR);
        psen_n  = !(in_data && kind == KIND_FETCH);
        rd_n    = !(in_data && kind == KIND_READ);
        wr_n    = !(in_data && kind == KIND_WRITE);
        done    = (phase == PH_REL);
        ready   = (phase == PH_IDLE);
    end

endmodule

// File: rtl/mbus_port.sv
module mbus_port
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  bus_phase_e               phase,
    input  bus_kind_e                kind,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic [ADDR_W-DATA_W-1:0] addr_hi
);
    always_comb begin
        addr_hi = addr[ADDR_W-1:DATA_W];
        ad_out  = '0;
        ad_oe   = 1'b0;
        case (phase)
            PH_ADDR, PH_HOLD: begin
                ad_out = addr[DATA_W-1:0];
                ad_oe  = 1'b1;
            end
            PH_DATA, PH_REL: begin
                if (kind == KIND_WRITE) begin
                    ad_out = wdata;
                    ad_oe  = 1'b1;
                end
            end
            default: begin
                ad_out = '0;
                ad_oe  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/mux_bus_master.sv
module mux_bus_master
    import mbus_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int DATA_CLKS = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [1:0]               req_kind,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     req_ready,
    output logic [DATA_W-1:0]        rsp_data,
    output logic                     rsp_done,
    output logic                     ale,
    output logic                     psen_n,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    input  logic [DATA_W-1:0]        ad_in
);
    bus_phase_e        phase;
    bus_kind_e         kind;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;

    mbus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DATA_CLKS(DATA_CLKS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ad_in     (ad_in),
        .phase     (phase),
        .kind      (kind),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rsp_data)
    );

    mbus_strobe u_strobe (
        .phase  (phase),
        .kind   (kind),
        .ale    (ale),
        .psen_n (psen_n),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .done   (rsp_done),
        .ready  (req_ready)
    );

    mbus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
        .phase   (phase),
        .kind    (kind),
        .addr    (addr),
        .wdata   (wdata),
        .ad_out  (ad_out),
        .ad_oe   (ad_oe),
        .addr_hi (addr_hi)
    );

endmodule

// File: rtl/mbus_checker.sv
module mbus_checker #(
    parameter int DATA_W = 8,
    parameter int HI_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_done,
    input logic              ale,
    input logic              psen_n,
    input logic              rd_n,
    input logic              wr_n,
    input logic              ad_oe,
    input logic [DATA_W-1:0] ad_out,
    input logic [HI_W-1:0]   addr_hi
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!ale && psen_n && rd_n && wr_n && !rsp_done));

    assert_ale_fall_holds_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale) |-> (ad_oe && ad_out == $past(ad_out)));

    assert_hi_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!psen_n || !rd_n || !wr_n) |-> $stable(addr_hi));

    assert_read_turnaround_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!psen_n || !rd_n) |-> !ad_oe);

    assert_write_drives_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ad_oe);

    assert_strobes_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!psen_n, !rd_n, !wr_n}) <= 1);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> (!rsp_done && req_ready));

endmodule

bind mux_bus_master mbus_checker #(.DATA_W(DATA_W), .HI_W(ADDR_W - DATA_W)) u_mbus_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .ale       (ale),
    .psen_n    (psen_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .ad_oe     (ad_oe),
    .ad_out    (ad_out),
    .addr_hi   (addr_hi)
);

// File: tb/test_mux_bus_master.sv
module test_mux_bus_master;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic [15:0] req_addr = 16'h0;
    logic [7:0]  req_wdata = 8'h0;
    logic        req_ready, rsp_done, ale, psen_n, rd_n, wr_n, ad_oe;
    logic [7:0]  rsp_data, addr_hi, ad_out, ad_in;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;
    bit run_live = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mux_bus_master i_mux_bus_master (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_data(rsp_data), .rsp_done(rsp_done), .ale(ale), .psen_n(psen_n),
        .rd_n(rd_n), .wr_n(wr_n), .addr_hi(addr_hi), .ad_out(ad_out),
        .ad_oe(ad_oe), .ad_in(ad_in)
    );

    // External device model: falling-edge latch, program store, data store.
    logic [7:0] lat_lo = 8'h0;
    logic [7:0] dev_mem [int];
    logic [7:0] ref_mem [int];

    function automatic logic [7:0] code_of(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
    endfunction

    function automatic logic [7:0] blank_of(input logic [15:0] a);
        return a[15:8] + a[7:0] + 8'h3C;
    endfunction

    always @(negedge ale) lat_lo = ad_out;

    always @(posedge wr_n) begin
        if (run_live) dev_mem[int'({addr_hi, lat_lo})] = ad_out;
    end

    always @* begin
        if (!psen_n) ad_in = code_of({addr_hi, lat_lo});
        else if (!rd_n) ad_in = dev_mem.exists(int'({addr_hi, lat_lo})) ?
                                dev_mem[int'({addr_hi, lat_lo})] : blank_of({addr_hi, lat_lo});
        else ad_in = 8'h00;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    typedef struct {
        logic [1:0]  kind;
        logic [15:0] addr;
        logic [7:0]  data;
    } item_t;

    item_t exp_q[$];
    int    done_seen = 0;

    // Driver: push expectation, present request for one clock.
    task automatic issue(input logic [1:0] k, input logic [15:0] a, input logic [7:0] w);
        item_t it;
        while (!req_ready) @(negedge clk);
        it.kind = k;
        it.addr = a;
        if (k == 2'b00) it.data = code_of(a);
        else if (k == 2'b01) it.data = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : blank_of(a);
        else begin
            it.data = w;
            ref_mem[int'(a)] = w;
        end
        exp_q.push_back(it);
        req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = w;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: strobe lengths, latency, latched address and data.
    int n_psen = 0, n_rd = 0, n_wr = 0, t_ale = -1;
    logic [15:0] seen_addr = 16'h0;
    always @(negedge clk) begin
        if (run_live) begin
            if (ale) begin
                n_psen = 0; n_rd = 0; n_wr = 0; t_ale = 0;
                check(ad_oe == 1'b1, "R2 ad_oe during ale", 32'(ad_oe), 1);
            end else if (t_ale >= 0) t_ale++;
            if (!psen_n) n_psen++;
            if (!rd_n) n_rd++;
            if (!wr_n) n_wr++;
            if (!psen_n || !rd_n || !wr_n) seen_addr = {addr_hi, lat_lo};
            if (ad_oe && (!psen_n || !rd_n)) check(0, "R5 contention", 1, 0);
            if (rsp_done) begin
                done_seen++;
                if (exp_q.size() == 0) check(0, "R8 unexpected done", 1, 0);
                else begin
                    item_t it;
                    it = exp_q.pop_front();
                    check(t_ale == 4, "R8 done latency", 32'(t_ale), 4);
                    check(seen_addr == it.addr, "R2 R3 latched address", seen_addr, it.addr);
                    case (it.kind)
                        2'b00: begin
                            check(n_psen == 2 && n_rd == 0 && n_wr == 0, "R4 fetch strobes",
                                  {n_psen[7:0], n_rd[7:0], n_wr[7:0]}, 32'h020000);
                            check(rsp_data == it.data, "R4 fetch data", rsp_data, it.data);
                        end
                        2'b01: begin
                            check(n_rd == 2 && n_psen == 0 && n_wr == 0, "R5 read strobes",
                                  {n_psen[7:0], n_rd[7:0], n_wr[7:0]}, 32'h000200);
                            check(rsp_data == it.data, "R5 read data", rsp_data, it.data);
                        end
                        default: begin
                            logic [7:0] got;
                            got = dev_mem.exists(int'(it.addr)) ? dev_mem[int'(it.addr)] : 8'hxx;
                            check(n_wr == 2 && n_psen == 0 && n_rd == 0, "R6 write strobes",
                                  {n_psen[7:0], n_rd[7:0], n_wr[7:0]}, 32'h000002);
                            check(got === it.data, "R6 write data", got, it.data);
                            check(ad_oe && ad_out == it.data, "R6 hold at release",
                                  {ad_oe, ad_out}, {1'b1, it.data});
                        end
                    endcase
                end
                t_ale = -1;
            end
        end
    end

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            check(0, "watchdog", 32'(cycles), WATCHDOG);
            finish_run();
        end
    end

    task automatic wait_idle;
        while (exp_q.size() != 0 || !req_ready) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(req_ready && !ale && psen_n && rd_n && wr_n && !rsp_done, "R1 in reset",
              {req_ready, ale, psen_n, rd_n, wr_n, rsp_done}, 6'b101110);
        rst_n = 1'b1;
        run_live = 1'b1;
        @(negedge clk);
        check(req_ready && !ale && psen_n && rd_n && wr_n && !rsp_done, "R1 after reset",
              {req_ready, ale, psen_n, rd_n, wr_n, rsp_done}, 6'b101110);

        // Fetches at extreme and alternating addresses
        issue(2'b00, 16'h0000, 8'h00);
        issue(2'b00, 16'hFFFF, 8'h00);
        issue(2'b00, 16'h55AA, 8'h00);
        issue(2'b00, 16'hAA55, 8'h00);
        // Reads of never-written locations
        issue(2'b01, 16'h1234, 8'h00);
        issue(2'b01, 16'hFF00, 8'h00);
        // Writes then read back
        issue(2'b10, 16'h1234, 8'hC3);
        issue(2'b10, 16'h00FF, 8'hFF);
        issue(2'b01, 16'h1234, 8'h00);
        issue(2'b01, 16'h00FF, 8'h00);
        // Fetch from an address written in data space: program space is separate
        issue(2'b00, 16'h1234, 8'h00);
        // Mixed sweep
        for (int i = 0; i < 12; i++) begin
            logic [15:0] a;
            a = 16'h0101 * 16'(i) ^ 16'h8421;
            issue(2'b10, a, 8'(i * 37 + 5));
            issue(2'b01, a, 8'h00);
            issue(2'b00, a, 8'h00);
        end
        wait_idle();

        // R8: requests during a busy cycle start nothing
        issue(2'b01, 16'h4242, 8'h00);
        req_valid = 1'b1; req_kind = 2'b10; req_addr = 16'h7E7E; req_wdata = 8'h99;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        issue(2'b01, 16'h7E7E, 8'h00);
        wait_idle();
        check(done_seen == 3 * 12 + 11 + 2, "R8 busy request ignored", 32'(done_seen), 49);

        // R9: reserved kind not accepted
        begin
            bit any_ale = 1'b0;
            bit all_ready = 1'b1;
            req_valid = 1'b1; req_kind = 2'b11; req_addr = 16'h3333;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (ale) any_ale = 1'b1;
                if (!req_ready) all_ready = 1'b0;
            end
            req_valid = 1'b0;
            check(!any_ale && all_ready, "R9 reserved kind", {any_ale, all_ready}, 2'b01);
        end
        // R1 idle again
        check(req_ready && !ale && psen_n && rd_n && wr_n, "R1 idle at end",
              {req_ready, ale, psen_n, rd_n, wr_n}, 5'b10111);
        check(exp_q.size() == 0, "R8 all cycles completed", 32'(exp_q.size()), 0);
        finish_run();
    end

endmodule